// File: doc/BRIEF.md
# Plane Latch Auto-Index Register Port

This block gives a host access to two 4-byte plane latches of a planar graphics controller through an 8-bit indexed register bus. The foreground colour latch is held entirely inside the block. The background data latch is also stored here. The host can reach it byte by byte, and the memory read path can fill all of it in one cycle. Both latches are exported in full to the pixel ALU.

The host can reach the foreground bytes either by addressing each one directly or by streaming through a single index. Streaming uses a plane pointer. The pointer steps forward modulo 4 after each write and drops back to plane 0 after each read. One control index loads both pointers from separate fields of its data byte. Background bytes are reached only by streaming.

The bulk load port has no ready signal. It is accepted in every cycle in which `ld_valid` is high, so the memory read path never sees back-pressure. The register bus likewise completes in the strobe cycle: read data is combinational while `reg_rd` is high, and every state change lands on the rising edge that closes that cycle.

Top module: `plane_latch_port`

## Requirements
- R1: After reset both plane pointers are 0 and all eight latch bytes are 0x00.
- R2: A write to index 0xEC, 0xED, 0xEE or 0xEF stores the data byte into foreground byte 0, 1, 2 or 3, where byte n is `fg_latch[8n+7:8n]`. The write does not move either pointer.
- R3: A write to index 0xF0 stores the data byte into the foreground byte chosen by the foreground pointer. That pointer then advances by one, wrapping from 3 to 0.
- R4: A write to index 0xF1 loads the background pointer from data bits [1:0] and the foreground pointer from data bits [5:4]. All other data bits are ignored and no latch byte changes.
- R5: A write to index 0xF2 stores the data byte into the background byte chosen by the background pointer, where byte n is `bg_latch[8n+7:8n]`. That pointer then advances by one, wrapping from 3 to 0.
- R6: While `reg_rd` is high with index 0xF0, `reg_rdata` shows the foreground byte chosen by the foreground pointer. At the closing edge the foreground pointer clears to 0.
- R7: While `reg_rd` is high with index 0xF2, `reg_rdata` shows the background byte chosen by the background pointer. At the closing edge the background pointer clears to 0.
- R8: A read of any other index returns 0xFF, and `reg_rdata` is 0xFF whenever `reg_rd` is low. A write to any index other than 0xEC–0xF2 changes no latch byte and no pointer.
- R9: While `ld_valid` is high, all four background bytes take `ld_data` at the next edge and neither pointer changes. If a 0xF2 write falls in the same cycle, the load data wins, but the background pointer still advances.
- R10: When `reg_wr` and `reg_rd` are both high, the write takes effect and the pointer clear of the read is suppressed. The read data still shows the pre-edge byte.
- R11: Latch bytes and pointers change only at the rising edge that ends a strobe or load cycle. The exported latch values are stable during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_index | input | 8 | Register index of the current access |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe, one access per cycle |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| ld_valid | input | 1 | Bulk background load, always accepted |
| ld_data | input | 32 | Bulk load data, byte n to background byte n |
| fg_latch | output | 32 | Foreground latch bytes 3..0 |
| bg_latch | output | 32 | Background latch bytes 3..0 |

## Verification
The bench streams five bytes through each auto-index so that the pointer wraps. A design that saturates the pointer or forgets to wrap would leave byte 0 holding its first value. It reads the same stream index twice in a row. A design that keeps the pointer after a read, or clears it before the data is chosen, returns the wrong byte on one of the two reads. It loads the pointer-select index with all unused bits set, which shows any decode that lets bits [7:6] or [3:2] leak into a pointer. It also collides a bulk load with a streaming write and a read with a write. A design with the wrong priority either loses the load data or keeps a pointer that should have moved.

// File: rtl/plp_pkg.sv
package plp_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_FG_DIRECT,
    ACC_FG_STREAM,
    ACC_PTR_SET,
    ACC_BG_STREAM
  } acc_e;

endpackage

// File: rtl/plp_decode.sv
module plp_decode
  import plp_pkg::*;
#(
  parameter int unsigned       IW            = 8,
  parameter int unsigned       LANES         = 4,
  parameter logic [IW-1:0]     IDX_FG_BASE   = 8'hEC,
  parameter logic [IW-1:0]     IDX_FG_STREAM = 8'hF0,
  parameter logic [IW-1:0]     IDX_PTR_SEL   = 8'hF1,
  parameter logic [IW-1:0]     IDX_BG_STREAM = 8'hF2,
  localparam int unsigned      PW            = $clog2(LANES)
) (
  input  logic [IW-1:0] index,
  output acc_e          kind,
  output logic [PW-1:0] lane
);

  logic [IW-1:0] offset;

  always_comb begin
    offset = index - IDX_FG_BASE;
    lane   = offset[PW-1:0];
    if (index == IDX_FG_STREAM)        kind = ACC_FG_STREAM;
    else if (index == IDX_PTR_SEL)     kind = ACC_PTR_SET;
    else if (index == IDX_BG_STREAM)   kind = ACC_BG_STREAM;
    else if (offset < IW'(LANES))      kind = ACC_FG_DIRECT;
    else                               kind = ACC_NONE;
  end

endmodule

// File: rtl/plp_ptr.sv
module plp_ptr #(
  parameter int unsigned  LANES = 4,
  localparam int unsigned PW    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [PW-1:0] set_val,
  input  logic          inc_en,
  input  logic          clr_en,
  output logic [PW-1:0] ptr
);

  logic [PW-1:0] ptr_next;

  always_comb begin
    if (ptr == PW'(LANES - 1)) ptr_next = '0;
    else                       ptr_next = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (set_en)  ptr <= set_val;
    else if (inc_en)  ptr <= ptr_next;
    else if (clr_en)  ptr <= '0;
  end

endmodule

// File: rtl/plp_bank.sv
module plp_bank #(
  parameter int unsigned  DW    = 8,
  parameter int unsigned  LANES = 4,
  localparam int unsigned PW    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PW-1:0]       wr_sel,
  input  logic [DW-1:0]       wr_data,
  input  logic                bulk_en,
  input  logic [LANES*DW-1:0] bulk_data,
  output logic [LANES*DW-1:0] q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g*DW +: DW] <= '0;
      else if (bulk_en)
        q[g*DW +: DW] <= bulk_data[g*DW +: DW];
      else if (wr_en && (wr_sel == PW'(g)))
        q[g*DW +: DW] <= wr_data;
    end
  end

endmodule

// File: rtl/plane_latch_port.sv
module plane_latch_port
  import plp_pkg::*;
#(
  parameter int unsigned   DW            = 8,
  parameter int unsigned   IW            = 8,
  parameter int unsigned   LANES         = 4,
  parameter int unsigned   FG_SEL_LSB    = 4,
  parameter logic [IW-1:0] IDX_FG_BASE   = 8'hEC,
  parameter logic [IW-1:0] IDX_FG_STREAM = 8'hF0,
  parameter logic [IW-1:0] IDX_PTR_SEL   = 8'hF1,
  parameter logic [IW-1:0] IDX_BG_STREAM = 8'hF2,
  localparam int unsigned  PW            = $clog2(LANES),
  localparam int unsigned  LW            = LANES * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] reg_index,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic [DW-1:0] reg_rdata,
  input  logic          ld_valid,
  input  logic [LW-1:0] ld_data,
  output logic [LW-1:0] fg_latch,
  output logic [LW-1:0] bg_latch
);

  acc_e          kind;
  logic [PW-1:0] direct_lane;
  logic [PW-1:0] fg_ptr;
  logic [PW-1:0] bg_ptr;
  logic          rd_only;
  logic          fg_wr_en;
  logic [PW-1:0] fg_wr_sel;

  plp_decode #(
    .IW(IW), .LANES(LANES),
    .IDX_FG_BASE(IDX_FG_BASE), .IDX_FG_STREAM(IDX_FG_STREAM),
    .IDX_PTR_SEL(IDX_PTR_SEL), .IDX_BG_STREAM(IDX_BG_STREAM)
  ) u_decode (
    .index (reg_index),
    .kind  (kind),
    .lane  (direct_lane)
  );

  assign rd_only   = reg_rd && !reg_wr;
  assign fg_wr_en  = reg_wr && (kind == ACC_FG_DIRECT || kind == ACC_FG_STREAM);
  assign fg_wr_sel = (kind == ACC_FG_DIRECT) ? direct_lane : fg_ptr;

  plp_ptr #(.LANES(LANES)) u_fg_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (reg_wr && kind == ACC_PTR_SET),
    .set_val (reg_wdata[FG_SEL_LSB +: PW]),
    .inc_en  (reg_wr && kind == ACC_FG_STREAM),
    .clr_en  (rd_only && kind == ACC_FG_STREAM),
    .ptr     (fg_ptr)
  );

  plp_ptr #(.LANES(LANES)) u_bg_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (reg_wr && kind == ACC_PTR_SET),
    .set_val (reg_wdata[PW-1:0]),
    .inc_en  (reg_wr && kind == ACC_BG_STREAM),
    .clr_en  (rd_only && kind == ACC_BG_STREAM),
    .ptr     (bg_ptr)
  );

  plp_bank #(.DW(DW), .LANES(LANES)) u_fg_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fg_wr_en),
    .wr_sel    (fg_wr_sel),
    .wr_data   (reg_wdata),
    .bulk_en   (1'b0),
    .bulk_data ({LW{1'b0}}),
    .q         (fg_latch)
  );

  plp_bank #(.DW(DW), .LANES(LANES)) u_bg_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr && kind == ACC_BG_STREAM),
    .wr_sel    (bg_ptr),
    .wr_data   (reg_wdata),
    .bulk_en   (ld_valid),
    .bulk_data (ld_data),
    .q         (bg_latch)
  );

  always_comb begin
    reg_rdata = '1;
    if (reg_rd) begin
      if (kind == ACC_FG_STREAM)      reg_rdata = fg_latch[fg_ptr*DW +: DW];
      else if (kind == ACC_BG_STREAM) reg_rdata = bg_latch[bg_ptr*DW +: DW];
    end
  end

endmodule

// File: rtl/plp_checker.sv
module plp_checker #(
  parameter int unsigned   DW            = 8,
  parameter int unsigned   IW            = 8,
  parameter int unsigned   LANES         = 4,
  parameter int unsigned   FG_SEL_LSB    = 4,
  parameter logic [IW-1:0] IDX_FG_BASE   = 8'hEC,
  parameter logic [IW-1:0] IDX_FG_STREAM = 8'hF0,
  parameter logic [IW-1:0] IDX_PTR_SEL   = 8'hF1,
  parameter logic [IW-1:0] IDX_BG_STREAM = 8'hF2,
  localparam int unsigned  PW            = $clog2(LANES),
  localparam int unsigned  LW            = LANES * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] reg_index,
  input logic [DW-1:0] reg_wdata,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [DW-1:0] reg_rdata,
  input logic          ld_valid,
  input logic [LW-1:0] ld_data,
  input logic [LW-1:0] fg_latch,
  input logic [LW-1:0] bg_latch,
  input logic [PW-1:0] fg_ptr,
  input logic [PW-1:0] bg_ptr
);

  logic [IW-1:0] ofs;
  assign ofs = reg_index - IDX_FG_BASE;

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ofs < IW'(LANES)) |=>
      fg_latch[$past(ofs[PW-1:0])*DW +: DW] == $past(reg_wdata)); // R2

  AST_FG_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_index == IDX_FG_STREAM) |=>
      fg_ptr == PW'(($past(fg_ptr) + 1) % LANES)); // R3

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_index == IDX_PTR_SEL) |=>
      (bg_ptr == $past(reg_wdata[PW-1:0]) &&
       fg_ptr == $past(reg_wdata[FG_SEL_LSB +: PW]))); // R4

  AST_BG_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_index == IDX_BG_STREAM) |=>
      bg_ptr == PW'(($past(bg_ptr) + 1) % LANES)); // R5

  AST_FG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_index == IDX_FG_STREAM) |=> fg_ptr == '0); // R6

  AST_BG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_index == IDX_BG_STREAM) |=> bg_ptr == '0); // R7

  AST_UNHANDLED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd || (reg_index != IDX_FG_STREAM && reg_index != IDX_BG_STREAM))
      |-> reg_rdata == '1); // R8

  AST_BULK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> bg_latch == $past(ld_data)); // R9

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reg_rd && !ld_valid) |=>
      ($stable(fg_latch) && $stable(bg_latch) && $stable(fg_ptr) && $stable(bg_ptr))); // R11

endmodule

bind plane_latch_port plp_checker #(
  .DW(DW), .IW(IW), .LANES(LANES), .FG_SEL_LSB(FG_SEL_LSB),
  .IDX_FG_BASE(IDX_FG_BASE), .IDX_FG_STREAM(IDX_FG_STREAM),
  .IDX_PTR_SEL(IDX_PTR_SEL), .IDX_BG_STREAM(IDX_BG_STREAM)
) u_plp_checker (
  .clk(clk), .rst_n(rst_n), .reg_index(reg_index), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .ld_valid(ld_valid), .ld_data(ld_data), .fg_latch(fg_latch),
  .bg_latch(bg_latch), .fg_ptr(fg_ptr), .bg_ptr(bg_ptr)
);

// File: tb/plane_latch_port_test.sv
module plane_latch_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_index = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] fg_latch;
  logic [31:0] bg_latch;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  plane_latch_port uut (
    .clk(clk), .rst_n(rst_n), .reg_index(reg_index), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .fg_latch(fg_latch), .bg_latch(bg_latch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_index = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk);
    reg_index = idx; reg_rd = 1'b1;
    #2 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk("R1 fg after reset", fg_latch, 32'h0);
    chk("R1 bg after reset", bg_latch, 32'h0);
    chk("R8 idle rdata", {24'h0, reg_rdata}, 32'hFF);
    rd(8'hF0, v); chk("R1 fg stream read", {24'h0, v}, 32'h0);
    rd(8'hF2, v); chk("R1 bg stream read", {24'h0, v}, 32'h0);
  endtask

  task automatic t_direct();
    do_reset();
    wr(8'hEC, 8'h11); wr(8'hED, 8'h22); wr(8'hEE, 8'h33); wr(8'hEF, 8'h44);
    chk("R2 direct bytes", fg_latch, 32'h44332211);
    chk("R2 bg untouched", bg_latch, 32'h0);
    @(negedge clk);
    reg_index = 8'hEC; reg_wdata = 8'h5C; reg_wr = 1'b1;
    #5 chk("R11 before edge", fg_latch, 32'h44332211);
    @(posedge clk); #1;
    chk("R11 after edge", fg_latch, 32'h4433225C);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic t_fg_stream();
    logic [7:0] v;
    do_reset();
    wr(8'hF0, 8'hA0); wr(8'hF0, 8'hA1); wr(8'hF0, 8'hA2);
    wr(8'hF0, 8'hA3); wr(8'hF0, 8'hA4);
    chk("R3 stream wrap", fg_latch, 32'hA3A2A1A4);
    rd(8'hF0, v); chk("R6 read at ptr 1", {24'h0, v}, 32'hA1);
    rd(8'hF0, v); chk("R6 read after clear", {24'h0, v}, 32'hA4);
  endtask

  task automatic t_ptr_set();
    logic [7:0] v;
    do_reset();
    wr(8'hEC, 8'h10); wr(8'hED, 8'h20); wr(8'hEE, 8'h30); wr(8'hEF, 8'h40);
    wr(8'hF1, 8'hCE);
    chk("R4 no latch change", fg_latch, 32'h40302010);
    rd(8'hF0, v); chk("R4 fg ptr from bits 5:4", {24'h0, v}, 32'h10);
    wr(8'hF1, 8'h31);
    wr(8'hF0, 8'h5A);
    wr(8'hF2, 8'hC1);
    chk("R4 fg ptr 3", fg_latch, 32'h5A302010);
    chk("R4 bg ptr 1", bg_latch, 32'h0000C100);
    wr(8'hF1, 8'hE6);
    rd(8'hF0, v); chk("R4 fg ptr 2 upper bits ignored", {24'h0, v}, 32'h30);
  endtask

  task automatic t_bg_stream();
    logic [7:0] v;
    do_reset();
    wr(8'hF2, 8'hB0); wr(8'hF2, 8'hB1); wr(8'hF2, 8'hB2);
    wr(8'hF2, 8'hB3); wr(8'hF2, 8'hB4);
    chk("R5 stream wrap", bg_latch, 32'hB3B2B1B4);
    chk("R5 fg untouched", fg_latch, 32'h0);
    rd(8'hF2, v); chk("R7 read at ptr 1", {24'h0, v}, 32'hB1);
    rd(8'hF2, v); chk("R7 read after clear", {24'h0, v}, 32'hB4);
  endtask

  task automatic t_unhandled();
    logic [7:0] v;
    do_reset();
    wr(8'hEC, 8'h77);
    rd(8'hEC, v); chk("R8 direct index read", {24'h0, v}, 32'hFF);
    rd(8'h00, v); chk("R8 index 0 read", {24'h0, v}, 32'hFF);
    rd(8'hF1, v); chk("R8 select index read", {24'h0, v}, 32'hFF);
    wr(8'h10, 8'h99); wr(8'hEB, 8'h99); wr(8'hF3, 8'h99);
    chk("R8 fg after stray writes", fg_latch, 32'h77);
    chk("R8 bg after stray writes", bg_latch, 32'h0);
    wr(8'hF0, 8'h88);
    chk("R8 fg ptr still 0", fg_latch, 32'h88);
  endtask

  task automatic t_bulk();
    logic [7:0] v;
    do_reset();
    wr(8'hF1, 8'h02);
    @(negedge clk); ld_data = 32'hDEADBEEF; ld_valid = 1'b1;
    @(negedge clk); ld_valid = 1'b0;
    chk("R9 bulk data", bg_latch, 32'hDEADBEEF);
    rd(8'hF2, v); chk("R9 bg ptr kept", {24'h0, v}, 32'hAD);
    wr(8'hF1, 8'h01);
    @(negedge clk);
    ld_data = 32'h01020304; ld_valid = 1'b1;
    reg_index = 8'hF2; reg_wdata = 8'h77; reg_wr = 1'b1;
    @(negedge clk); ld_valid = 1'b0; reg_wr = 1'b0;
    chk("R9 load beats stream write", bg_latch, 32'h01020304);
    rd(8'hF2, v); chk("R9 ptr still advanced", {24'h0, v}, 32'h02);
  endtask

  task automatic t_rdwr();
    logic [7:0] v;
    do_reset();
    wr(8'hEC, 8'hE0); wr(8'hED, 8'hE1); wr(8'hEE, 8'hE2);
    wr(8'hF1, 8'h10);
    @(negedge clk);
    reg_index = 8'hF0; reg_wdata = 8'h99; reg_wr = 1'b1; reg_rd = 1'b1;
    #2 chk("R10 read data pre-edge", {24'h0, reg_rdata}, 32'hE1);
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R10 write applied", fg_latch, 32'h00E299E0);
    rd(8'hF0, v); chk("R10 ptr advanced not cleared", {24'h0, v}, 32'hE2);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_direct();
    t_fg_stream();
    t_ptr_set();
    t_bg_stream();
    t_unhandled();
    t_bulk();
    t_rdwr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule